// File: doc/BRIEF.md
# Probe Control Register with Sticky Sense Flags

This block is the control and status word of a debug probe. Two bus addresses reach one register. The first address sets bits and the second clears them, so software can change one bit without reading the word first. The control bits drive the target system-reset line, the test-access-port reset line, the target power switch, two indicator LEDs and the enable for adaptive (returned) clocking.

Three status bits are sticky. Each one records an event that arrives on an asynchronous sense line:
- the target system reset was seen asserted,
- target power dropped out,
- the returned clock timed out.

A sticky bit stays set until software re-arms it. Re-arming loads the current synchronized level of the sense line, which clears history that is no longer true. The reset and power flags re-arm through the set address. The clock-timeout flag re-arms through the clear address.

Top module: `probe_ctl_regs`

## Requirements
- R1: A write to byte offset 0x10 sets every control bit whose write-data bit is 1. The control bits are 0, 1, 3, 4, 5 and 8. The change is visible after the write's clock edge.
- R2: A write to byte offset 0x14 clears every control bit whose write-data bit is 1.
- R3: A control bit written as 0 keeps its value at both addresses. With no write to 0x10 or 0x14, the control bits hold.
- R4: The control bits map to pins as follows:
  - bit 0 drives `sys_rst_o`,
  - bit 1 drives `tap_rst_o`,
  - bit 3 set switches target power off (`tgt_pwr_on_o` low),
  - bits 4 and 5 drive `led_o[0]` and `led_o[1]`,
  - bit 8 drives `rclk_en_o`.
- R5: Read bit 6 is sticky. It becomes 1 when the synchronized system-reset sense is high, and it stays 1 after the sense falls until software re-arms it.
- R6: A write of 1 to bit 6 or bit 7 at offset 0x10 re-arms that flag. The flag loads the current synchronized sense level: 0 if the line has been low for at least two cycles, 1 if it is still high.
- R7: Read bit 7 is the sticky power-dropout flag. It behaves like bit 6, fed from `pwr_drop_sense_i`.
- R8: Read bit 10 is the sticky returned-clock timeout flag. It is re-armed by writing 1 to bit 10 at offset 0x14. A bit-10 write at 0x10 has no effect, and bit-6 or bit-7 writes at 0x14 have no effect.
- R9: Each sense input passes through a two-flop synchronizer. When an input rises and is held, its flag still reads 0 after two rising edges and reads 1 after the third.
- R10: Reads at 0x10 and at 0x14 both return the control bits merged with the sticky bits. All other bits read 0. Any other address reads 0, and writes to it are ignored.
- R11: After reset, all control and sticky bits are 0, so target power is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data (bit mask) |
| rdata_o | output | 32 | Read data, combinational on `addr_i` |
| sys_rst_o | output | 1 | Target system reset drive |
| tap_rst_o | output | 1 | TAP reset drive |
| tgt_pwr_on_o | output | 1 | Target power switch, 1 = on |
| led_o | output | 2 | Indicator LEDs |
| rclk_en_o | output | 1 | Adaptive clocking enable |
| sys_rst_sense_i | input | 1 | Asynchronous system-reset sense |
| pwr_drop_sense_i | input | 1 | Asynchronous power-dropout sense |
| rclk_timeout_i | input | 1 | Asynchronous returned-clock timeout event |

## Verification
The bench targets four corner cases:
- **Re-arm after the sense has fallen.** A flag that only ever set would stay at 1 here, and a flag that merely cleared would lose an event that is still active.
- **Cross-address writes.** Bit 10 written at the set address and bits 6 and 7 written at the clear address must change nothing. A design that decoded the re-arm on the wrong address would drop a flag early.
- **Synchronizer latency.** The flag is read after two and after three edges. A missing or extra flop shows up as an early or a late 1.
- **Partial masks.** Zero bits in the write mask must leave their control bits alone. A read-modify-write style design would clobber neighbouring bits.

// File: rtl/probe_ctl_pkg.sv
package probe_ctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned N_STICKY = 3;

  localparam logic [ADDR_W-1:0] SET_OFFS = 8'h10;
  localparam logic [ADDR_W-1:0] CLR_OFFS = 8'h14;

  localparam int unsigned B_SYS_RST = 0;
  localparam int unsigned B_TAP_RST = 1;
  localparam int unsigned B_PWR_OFF = 3;
  localparam int unsigned B_LED0    = 4;
  localparam int unsigned B_LED1    = 5;
  localparam int unsigned B_RCLK_EN = 8;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    (32'd1 << B_SYS_RST) | (32'd1 << B_TAP_RST) | (32'd1 << B_PWR_OFF) |
    (32'd1 << B_LED0) | (32'd1 << B_LED1) | (32'd1 << B_RCLK_EN);

  // sticky index: 0 = system reset seen, 1 = power dropout, 2 = rclk timeout
  localparam int unsigned STK_POS [N_STICKY] = '{6, 7, 10};
  localparam bit          STK_CLR [N_STICKY] = '{1'b0, 1'b0, 1'b1};
endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] rearm_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q[i] <= 1'b0;
      else if (rearm_i[i]) flag_q[i] <= evt_i[i];  // drop history, keep live level
      else                 flag_q[i] <= flag_q[i] | evt_i[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ctrl_bank.sv
module ctrl_bank #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] eff;

  assign eff = mask_i & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (set_i) q <= q | eff;
    else if (clr_i) q <= q & ~eff;
  end

  assign q_o = q;
endmodule

// File: rtl/probe_ctl_regs.sv
module probe_ctl_regs
  import probe_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sys_rst_o,
  output logic              tap_rst_o,
  output logic              tgt_pwr_on_o,
  output logic [1:0]        led_o,
  output logic              rclk_en_o,
  input  logic              sys_rst_sense_i,
  input  logic              pwr_drop_sense_i,
  input  logic              rclk_timeout_i
);
  logic                hit_set, hit_clr;
  logic [DATA_W-1:0]   ctrl_q;
  logic [N_STICKY-1:0] sense_raw, sense_s, rearm, sticky_q;
  logic [DATA_W-1:0]   stk_word;

  assign hit_set = wr_i && (addr_i == SET_OFFS);
  assign hit_clr = wr_i && (addr_i == CLR_OFFS);

  ctrl_bank #(.W(DATA_W), .MASK(CTRL_MASK)) u_ctrl (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (hit_set), .clr_i(hit_clr),
    .mask_i(wdata_i), .q_o  (ctrl_q)
  );

  assign sense_raw = {rclk_timeout_i, pwr_drop_sense_i, sys_rst_sense_i};

  sense_sync #(.W(N_STICKY), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sense_raw), .q_o(sense_s)
  );

  for (genvar i = 0; i < N_STICKY; i++) begin : g_stk
    if (STK_CLR[i]) begin : g_on_clr
      assign rearm[i] = hit_clr && wdata_i[STK_POS[i]];
    end else begin : g_on_set
      assign rearm[i] = hit_set && wdata_i[STK_POS[i]];
    end
  end

  sticky_bank #(.W(N_STICKY)) u_stk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evt_i(sense_s), .rearm_i(rearm), .flag_o(sticky_q)
  );

  always_comb begin
    stk_word = '0;
    for (int i = 0; i < N_STICKY; i++) stk_word[STK_POS[i]] = sticky_q[i];
  end

  assign rdata_o = (addr_i == SET_OFFS || addr_i == CLR_OFFS) ? (ctrl_q | stk_word) : '0;

  assign sys_rst_o    = ctrl_q[B_SYS_RST];
  assign tap_rst_o    = ctrl_q[B_TAP_RST];
  assign tgt_pwr_on_o = ~ctrl_q[B_PWR_OFF];
  assign led_o        = {ctrl_q[B_LED1], ctrl_q[B_LED0]};
  assign rclk_en_o    = ctrl_q[B_RCLK_EN];
endmodule

// File: rtl/probe_ctl_regs_chk.sv
module probe_ctl_regs_chk
  import probe_ctl_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   ctrl_q,
  input logic [N_STICKY-1:0] sticky_q
);
  logic w_set, w_clr;
  assign w_set = wr_i && addr_i == SET_OFFS;
  assign w_clr = wr_i && addr_i == CLR_OFFS;

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_set |=> ((ctrl_q & $past(wdata_i) & CTRL_MASK) == ($past(wdata_i) & CTRL_MASK))); // R1
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_clr |=> ((ctrl_q & $past(wdata_i) & CTRL_MASK) == '0)); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_set || w_clr) |=> $stable(ctrl_q)); // R3
  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_set |=> ((ctrl_q & $past(ctrl_q)) == $past(ctrl_q))); // R3
  AST_SRST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_q[0] && !(w_set && wdata_i[6])) |=> sticky_q[0]); // R5
  AST_DROP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_q[1] && !(w_set && wdata_i[7])) |=> sticky_q[1]); // R7
  AST_RCLK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_q[2] && !(w_clr && wdata_i[10])) |=> sticky_q[2]); // R8
endmodule

bind probe_ctl_regs probe_ctl_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .ctrl_q(ctrl_q), .sticky_q(sticky_q)
);

// File: tb/sim_probe_ctl_regs.sv
module sim_probe_ctl_regs;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr_i = 8'h10;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sys_rst_o, tap_rst_o, tgt_pwr_on_o, rclk_en_o;
  logic [1:0]  led_o;
  logic [2:0]  sense = '0;   // {rclk, pwr drop, srst}

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_ctrl;
  logic [2:0]  m_s1, m_s2, m_stk;

  localparam logic [31:0] CMASK = 32'h0000_013B;

  always #10 clk = ~clk;

  probe_ctl_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .sys_rst_o(sys_rst_o), .tap_rst_o(tap_rst_o),
    .tgt_pwr_on_o(tgt_pwr_on_o), .led_o(led_o), .rclk_en_o(rclk_en_o),
    .sys_rst_sense_i(sense[0]), .pwr_drop_sense_i(sense[1]), .rclk_timeout_i(sense[2])
  );

  function automatic logic [31:0] exp_rd();
    return m_ctrl | (32'(m_stk[0]) << 6) | (32'(m_stk[1]) << 7) | (32'(m_stk[2]) << 10);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: present write, advance model on the edge
  task automatic tick(input logic [7:0] a, input logic [31:0] d, input logic w);
    logic [2:0] rearm;
    addr_i = a; wdata_i = d; wr_i = w;
    @(posedge clk);
    rearm = '0;
    if (w && a == 8'h10) begin
      m_ctrl = m_ctrl | (d & CMASK);
      rearm[0] = d[6]; rearm[1] = d[7];
    end else if (w && a == 8'h14) begin
      m_ctrl = m_ctrl & ~(d & CMASK);
      rearm[2] = d[10];
    end
    for (int i = 0; i < 3; i++) m_stk[i] = rearm[i] ? m_s2[i] : (m_stk[i] | m_s2[i]);
    m_s2 = m_s1; m_s1 = sense;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [31:0] e;
    e = exp_rd();
    wr_i = 0;
    addr_i = 8'h10; #1; chk(rdata_o == e, req, rdata_o, e);
    addr_i = 8'h14; #1; chk(rdata_o == e, req, rdata_o, e);
    chk({rclk_en_o, led_o, tgt_pwr_on_o, tap_rst_o, sys_rst_o} ==
        {m_ctrl[8], m_ctrl[5:4], ~m_ctrl[3], m_ctrl[1:0]}, "R4 pins",
        {26'd0, rclk_en_o, led_o, tgt_pwr_on_o, tap_rst_o, sys_rst_o},
        {26'd0, m_ctrl[8], m_ctrl[5:4], ~m_ctrl[3], m_ctrl[1:0]});
  endtask

  task automatic rd_bit(input int b, input logic exp, input string req);
    addr_i = 8'h10; wr_i = 0; #1;
    chk(rdata_o[b] == exp, req, {31'd0, rdata_o[b]}, {31'd0, exp});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    m_ctrl = '0; m_s1 = '0; m_s2 = '0; m_stk = '0;
    repeat (3) @(negedge clk);
    check_all("R11 reset");
    chk(tgt_pwr_on_o == 1'b1, "R11 power on", {31'd0, tgt_pwr_on_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk);

    tick(8'h10, 32'h1, 1);
    chk(sys_rst_o == 1, "R1 set srst", {31'd0, sys_rst_o}, 32'd1);
    tick(8'h10, 32'h0000_0132, 1);
    check_all("R1 set multi");
    chk(rclk_en_o && led_o == 2'b11 && tap_rst_o, "R4 led/rclk/trst",
        {29'd0, rclk_en_o, led_o}, 32'h7);
    tick(8'h10, 32'h8, 1);
    chk(tgt_pwr_on_o == 0, "R4 power off", {31'd0, tgt_pwr_on_o}, 32'd0);
    tick(8'h14, 32'h8, 1);
    chk(tgt_pwr_on_o == 1, "R2 power back on", {31'd0, tgt_pwr_on_o}, 32'd1);
    tick(8'h14, 32'h10, 1);
    chk(led_o == 2'b10 && sys_rst_o && tap_rst_o && rclk_en_o, "R3 zero bits keep",
        {30'd0, led_o}, 32'h2);
    check_all("R2 clear led0");
    tick(8'h20, 32'hFFFF_FFFF, 1);
    check_all("R10 other addr write ignored");
    addr_i = 8'h18; #1;
    chk(rdata_o == 0, "R10 other addr reads 0", rdata_o, 32'd0);

    // R9 latency and R5 stickiness
    sense[0] = 1'b1;
    tick(8'h00, 0, 0); rd_bit(6, 0, "R9 after one edge");
    tick(8'h00, 0, 0); rd_bit(6, 0, "R9 after two edges");
    tick(8'h00, 0, 0); rd_bit(6, 1, "R9 after three edges");
    tick(8'h10, 32'h40, 1); rd_bit(6, 1, "R6 rearm while high");
    sense[0] = 1'b0;
    repeat (4) tick(8'h00, 0, 0);
    rd_bit(6, 1, "R5 held after sense low");
    tick(8'h14, 32'h40, 1); rd_bit(6, 1, "R8 clr addr bit6 ignored");
    tick(8'h10, 32'h40, 1); rd_bit(6, 0, "R6 rearm clears");

    // R7 power dropout
    sense[1] = 1'b1; tick(8'h00, 0, 0); sense[1] = 1'b0;
    repeat (3) tick(8'h00, 0, 0);
    rd_bit(7, 1, "R7 dropout latched");
    tick(8'h10, 32'h80, 1); rd_bit(7, 0, "R7 rearm clears");

    // R8 rclk timeout
    sense[2] = 1'b1; tick(8'h00, 0, 0); sense[2] = 1'b0;
    repeat (3) tick(8'h00, 0, 0);
    rd_bit(10, 1, "R8 timeout latched");
    tick(8'h10, 32'h400, 1); rd_bit(10, 1, "R8 set addr bit10 ignored");
    tick(8'h14, 32'h400, 1); rd_bit(10, 0, "R8 clear addr rearms");
    check_all("R10 merged read");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int unsigned r;
      r = $urandom_range(0, 9);
      a = (r < 4) ? 8'h10 : (r < 8) ? 8'h14 : 8'($urandom_range(0, 255));
      d = $urandom;
      if ($urandom_range(0, 7) == 0) sense[0] = ~sense[0];
      if ($urandom_range(0, 7) == 0) sense[1] = ~sense[1];
      if ($urandom_range(0, 7) == 0) sense[2] = ~sense[2];
      tick(a, d, ($urandom_range(0, 2) != 0));
      if (n % 4 == 0) check_all("R1 R2 R3 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule